// File: doc/BRIEF.md
# PCIe Root-Port Interrupt Aggregator

This block gathers the interrupt events that a PCIe link controller reports and folds them into a single interrupt line for the host. Events are kept in two layers of sticky status.

The first layer has three banks: a 32-vector message-signalled-interrupt (MSI) bank, a link-event bank and an auxiliary-event bank. The link-event bank records legacy INTx assert and deassert messages and the MSI-pending summary. The auxiliary-event bank records power-state changes, flushes and a second copy of the INTx assert events.

The second layer is a host status register. One of its bits, the core summary, is set whenever either link-level bank holds an unmasked bit. The output line follows the unmasked content of the host register.

Every status register is cleared by writing ones. Every status register has a companion mask in which a one blocks the bit from propagating upward, while the status itself still records the event. Software reads and writes all registers through a simple select/data port. The data of the most recent MSI is kept in a read-only payload register.

Top module: `pcie_irq_aggr`

## Requirements
- R1: One cycle after reset, every status register reads as zero, `irq_o` is low, and every mask register reads as its implemented-bit set. These sets are 0x07FFFFFF for the link mask, 0x00000FF0 for the auxiliary mask, 0xFFFFFFFF for the MSI mask and 0x00FFF0FB for the host mask.
- R2: A pulse on `intx_up[n]` sets link status bit 16+n. A pulse on `intx_down[n]` sets link status bit 20+n. Both are visible from the clock edge that samples the pulse (n = 0..3).
- R3: A pulse on `pm_evt` sets auxiliary status bit 4. A pulse on `flush_evt` sets auxiliary status bit 5. A pulse on `intx_up[n]` sets auxiliary status bit 8+n. All are visible from the sampling edge.
- R4: When `msi_valid` is high, MSI status bit `msi_vec` is set at that edge and the payload register captures `msi_data` (8 bits, zero-extended on read). This happens whatever the MSI mask holds.
- R5: Link status bit 24 is set on the edge after any MSI status bit is pending with a zero mask bit.
- R6: Writing a status register clears exactly the bits written as one. Bits written as zero are untouched. Bits outside the implemented set always read as zero, including after writes to status or mask registers.
- R7: A mask bit of one keeps the status bit from reaching the next level. A masked MSI vector does not set link bit 24, and a masked link bit does not set host bit 16.
- R8: Host status bit 16 is set on the edge after the link or auxiliary bank holds any unmasked bit.
- R9: `irq_o` is high exactly while the host status has a bit whose host mask bit is zero.
- R10: An event arriving in the same cycle as a write-one-to-clear of its status bit leaves the bit set.
- R11: `reg_sel` encoding: 0 link status, 1 link mask, 2 auxiliary status, 3 auxiliary mask, 4 MSI status, 5 MSI mask, 6 MSI payload (read-only), 7 host status, 8 host mask. Any other select reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intx_up | input | 4 | Legacy INTA..INTD assert event pulses |
| intx_down | input | 4 | Legacy INTA..INTD deassert event pulses |
| pm_evt | input | 1 | Power-state change event pulse |
| flush_evt | input | 1 | Flush event pulse |
| msi_valid | input | 1 | MSI arrival strobe |
| msi_vec | input | 5 | Vector index of the arriving MSI |
| msi_data | input | 8 | Significant payload byte of the arriving MSI |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| irq_o | output | 1 | Aggregated interrupt line |

## Verification
Two operations can coincide on the same status bit: a hardware event that sets a bit, and a software write that clears it. The bench drives an INTx assert pulse in the very cycle that it writes a one to clear the matching link status bit. It then reads the register back and expects the bit to be still set; a later clear with no event must drop it. The same collision arises inside the hierarchy whenever a summary bit is cleared while its source is still pending. The bench orders its clears from the MSI bank upward and checks that each level reads zero only once its source is gone.

// File: rtl/pcie_irq_pkg.sv
package pcie_irq_pkg;
    localparam int REG_W       = 32;
    localparam int SEL_W       = 4;
    localparam int NUM_INTX    = 4;
    localparam int MSI_VECS    = 32;
    localparam int MSI_IDX_W   = $clog2(MSI_VECS);
    localparam int MSI_DATA_W  = 8;

    localparam logic [SEL_W-1:0] SEL_LNK_STAT  = 4'd0;
    localparam logic [SEL_W-1:0] SEL_LNK_MASK  = 4'd1;
    localparam logic [SEL_W-1:0] SEL_AUX_STAT  = 4'd2;
    localparam logic [SEL_W-1:0] SEL_AUX_MASK  = 4'd3;
    localparam logic [SEL_W-1:0] SEL_MSI_STAT  = 4'd4;
    localparam logic [SEL_W-1:0] SEL_MSI_MASK  = 4'd5;
    localparam logic [SEL_W-1:0] SEL_MSI_DATA  = 4'd6;
    localparam logic [SEL_W-1:0] SEL_HOST_STAT = 4'd7;
    localparam logic [SEL_W-1:0] SEL_HOST_MASK = 4'd8;

    localparam logic [REG_W-1:0] LNK_IMPL  = 32'h07FF_FFFF;
    localparam logic [REG_W-1:0] AUX_IMPL  = 32'h0000_0FF0;
    localparam logic [REG_W-1:0] MSI_IMPL  = 32'hFFFF_FFFF;
    localparam logic [REG_W-1:0] HOST_IMPL = 32'h00FF_F0FB;

    localparam int LNK_MSI_BIT    = 24;
    localparam int LNK_UP_BASE    = 16;
    localparam int LNK_DOWN_BASE  = 20;
    localparam int AUX_PM_BIT     = 4;
    localparam int AUX_FLUSH_BIT  = 5;
    localparam int AUX_UP_BASE    = 8;
    localparam int HOST_CORE_BIT  = 16;

    typedef struct packed {
        logic [NUM_INTX-1:0] up;
        logic [NUM_INTX-1:0] down;
        logic                pm;
        logic                flush;
    } link_evt_t;

    function automatic logic [REG_W-1:0] lnk_set_vec(input link_evt_t ev, input logic msi_pend);
        logic [REG_W-1:0] v;
        v = '0;
        for (int n = 0; n < NUM_INTX; n++) begin
            v[LNK_UP_BASE + n]   = ev.up[n];
            v[LNK_DOWN_BASE + n] = ev.down[n];
        end
        v[LNK_MSI_BIT] = msi_pend;
        return v;
    endfunction

    function automatic logic [REG_W-1:0] aux_set_vec(input link_evt_t ev);
        logic [REG_W-1:0] v;
        v = '0;
        for (int n = 0; n < NUM_INTX; n++) v[AUX_UP_BASE + n] = ev.up[n];
        v[AUX_PM_BIT]    = ev.pm;
        v[AUX_FLUSH_BIT] = ev.flush;
        return v;
    endfunction
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int               WIDTH = 32,
    parameter logic [WIDTH-1:0] IMPL  = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_vec,
    input  logic             clr_we,
    input  logic             mask_we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] status,
    output logic [WIDTH-1:0] mask,
    output logic             active
);
    logic [WIDTH-1:0] clr_vec;

    assign clr_vec = clr_we ? wdata : '0;

    // Set is ORed after the clear, so a colliding event wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= IMPL;
        end else begin
            status <= ((status & ~clr_vec) | set_vec) & IMPL;
            if (mask_we) mask <= wdata & IMPL;
        end
    end

    assign active = |(status & ~mask);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((status & $past(set_vec & IMPL)) == $past(set_vec & IMPL)));

    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((status & $past(wdata & ~set_vec)) == '0));

    assert_mask_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (mask == IMPL && status == '0));
endmodule

// File: rtl/pcie_irq_aggr.sv
module pcie_irq_aggr
    import pcie_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_INTX-1:0]   intx_up,
    input  logic [NUM_INTX-1:0]   intx_down,
    input  logic                  pm_evt,
    input  logic                  flush_evt,
    input  logic                  msi_valid,
    input  logic [MSI_IDX_W-1:0]  msi_vec,
    input  logic [MSI_DATA_W-1:0] msi_data,
    input  logic                  reg_we,
    input  logic [SEL_W-1:0]      reg_sel,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic                  irq_o
);
    link_evt_t             evt;
    logic [REG_W-1:0]      msi_set, lnk_set, aux_set, host_set;
    logic [REG_W-1:0]      msi_stat, msi_mask, lnk_stat, lnk_mask;
    logic [REG_W-1:0]      aux_stat, aux_mask, host_stat, host_mask;
    logic                  msi_act, lnk_act, aux_act, host_act;
    logic [MSI_DATA_W-1:0] payload_q;

    assign evt      = '{up: intx_up, down: intx_down, pm: pm_evt, flush: flush_evt};
    assign msi_set  = msi_valid ? (REG_W'(1) << msi_vec) : '0;
    assign lnk_set  = lnk_set_vec(evt, msi_act);
    assign aux_set  = aux_set_vec(evt);
    assign host_set = (lnk_act | aux_act) ? (REG_W'(1) << HOST_CORE_BIT) : '0;

    irq_status_bank #(.WIDTH(REG_W), .IMPL(MSI_IMPL)) u_msi (
        .clk(clk), .rst(rst), .set_vec(msi_set),
        .clr_we(reg_we && reg_sel == SEL_MSI_STAT),
        .mask_we(reg_we && reg_sel == SEL_MSI_MASK),
        .wdata(reg_wdata), .status(msi_stat), .mask(msi_mask), .active(msi_act));

    irq_status_bank #(.WIDTH(REG_W), .IMPL(LNK_IMPL)) u_lnk (
        .clk(clk), .rst(rst), .set_vec(lnk_set),
        .clr_we(reg_we && reg_sel == SEL_LNK_STAT),
        .mask_we(reg_we && reg_sel == SEL_LNK_MASK),
        .wdata(reg_wdata), .status(lnk_stat), .mask(lnk_mask), .active(lnk_act));

    irq_status_bank #(.WIDTH(REG_W), .IMPL(AUX_IMPL)) u_aux (
        .clk(clk), .rst(rst), .set_vec(aux_set),
        .clr_we(reg_we && reg_sel == SEL_AUX_STAT),
        .mask_we(reg_we && reg_sel == SEL_AUX_MASK),
        .wdata(reg_wdata), .status(aux_stat), .mask(aux_mask), .active(aux_act));

    irq_status_bank #(.WIDTH(REG_W), .IMPL(HOST_IMPL)) u_host (
        .clk(clk), .rst(rst), .set_vec(host_set),
        .clr_we(reg_we && reg_sel == SEL_HOST_STAT),
        .mask_we(reg_we && reg_sel == SEL_HOST_MASK),
        .wdata(reg_wdata), .status(host_stat), .mask(host_mask), .active(host_act));

    always_ff @(posedge clk) begin
        if (rst)            payload_q <= '0;
        else if (msi_valid) payload_q <= msi_data;
    end

    always_comb begin
        case (reg_sel)
            SEL_LNK_STAT:  reg_rdata = lnk_stat;
            SEL_LNK_MASK:  reg_rdata = lnk_mask;
            SEL_AUX_STAT:  reg_rdata = aux_stat;
            SEL_AUX_MASK:  reg_rdata = aux_mask;
            SEL_MSI_STAT:  reg_rdata = msi_stat;
            SEL_MSI_MASK:  reg_rdata = msi_mask;
            SEL_MSI_DATA:  reg_rdata = REG_W'(payload_q);
            SEL_HOST_STAT: reg_rdata = host_stat;
            SEL_HOST_MASK: reg_rdata = host_mask;
            default:       reg_rdata = '0;
        endcase
    end

    assign irq_o = host_act;

    assert_msi_arrival_R4: assert property (@(posedge clk) disable iff (rst)
        msi_valid |=> (msi_stat[$past(msi_vec)] && payload_q == $past(msi_data)));

    assert_msi_summary_R5: assert property (@(posedge clk) disable iff (rst)
        (|(msi_stat & ~msi_mask)) |=> lnk_stat[LNK_MSI_BIT]);

    assert_core_summary_R8: assert property (@(posedge clk) disable iff (rst)
        ((|(lnk_stat & ~lnk_mask)) || (|(aux_stat & ~aux_mask))) |=> host_stat[HOST_CORE_BIT]);

    assert_irq_quiet_after_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> !irq_o);
endmodule

// File: tb/pcie_irq_aggr_tb_top.sv
module pcie_irq_aggr_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  intx_up = '0, intx_down = '0;
    logic        pm_evt = 1'b0, flush_evt = 1'b0, msi_valid = 1'b0;
    logic [4:0]  msi_vec = '0;
    logic [7:0]  msi_data = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    pcie_irq_aggr dut_i (
        .clk(clk), .rst(rst), .intx_up(intx_up), .intx_down(intx_down),
        .pm_evt(pm_evt), .flush_evt(flush_evt), .msi_valid(msi_valid),
        .msi_vec(msi_vec), .msi_data(msi_data), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o));

    // Table entry: {up[3:0], down[3:0], pm, flush, sel[3:0], expected[31:0]}
    localparam int NVEC = 9;
    localparam logic [45:0] VEC [NVEC] = '{
        {4'b0001, 4'b0000, 1'b0, 1'b0, 4'd0, 32'h0001_0000},  // R2
        {4'b0001, 4'b0000, 1'b0, 1'b0, 4'd2, 32'h0000_0100},  // R3
        {4'b1000, 4'b0000, 1'b0, 1'b0, 4'd0, 32'h0008_0000},  // R2
        {4'b1000, 4'b0000, 1'b0, 1'b0, 4'd2, 32'h0000_0800},  // R3
        {4'b0000, 4'b0100, 1'b0, 1'b0, 4'd0, 32'h0040_0000},  // R2
        {4'b0000, 4'b1111, 1'b0, 1'b0, 4'd0, 32'h00F0_0000},  // R2
        {4'b0000, 4'b0000, 1'b1, 1'b0, 4'd2, 32'h0000_0010},  // R3
        {4'b0000, 4'b0000, 1'b0, 1'b1, 4'd2, 32'h0000_0020},  // R3
        {4'b1010, 4'b0101, 1'b0, 1'b0, 4'd0, 32'h005A_0000}   // R2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [3:0] sel, input logic [31:0] data);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] sel, output logic [31:0] data);
        reg_sel = sel;
        #1;
        data = reg_rdata;
    endtask

    task automatic rd_check(input string req, input logic [3:0] sel, input logic [31:0] exp);
        logic [31:0] v;
        rd(sel, v);
        check(req, v, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        tick();

        // R1 reset state
        rd_check("R1 lnk stat", 4'd0, 32'h0);
        rd_check("R1 lnk mask", 4'd1, 32'h07FF_FFFF);
        rd_check("R1 aux stat", 4'd2, 32'h0);
        rd_check("R1 aux mask", 4'd3, 32'h0000_0FF0);
        rd_check("R1 msi stat", 4'd4, 32'h0);
        rd_check("R1 msi mask", 4'd5, 32'hFFFF_FFFF);
        rd_check("R1 msi data", 4'd6, 32'h0);
        rd_check("R1 host stat", 4'd7, 32'h0);
        rd_check("R1 host mask", 4'd8, 32'h00FF_F0FB);
        check("R1 irq", {31'b0, irq_o}, 32'h0);

        // Table walk: R2/R3 bit positions
        for (int i = 0; i < NVEC; i++) begin
            wr(4'd0, 32'hFFFF_FFFF);
            wr(4'd2, 32'hFFFF_FFFF);
            {intx_up, intx_down, pm_evt, flush_evt} = VEC[i][45:36];
            tick();
            {intx_up, intx_down, pm_evt, flush_evt} = '0;
            rd_check("R2_R3 table", VEC[i][35:32], VEC[i][31:0]);
        end
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd2, 32'hFFFF_FFFF);
        rd_check("R6 lnk cleared", 4'd0, 32'h0);
        check("R7 irq stays low with masks", {31'b0, irq_o}, 32'h0);

        // R6 unimplemented bits and R11 decode
        wr(4'd1, 32'hFFFF_FFFF);
        rd_check("R6 lnk mask impl", 4'd1, 32'h07FF_FFFF);
        wr(4'd8, 32'hFFFF_FFFF);
        rd_check("R6 host mask impl", 4'd8, 32'h00FF_F0FB);
        rd_check("R11 unused select", 4'd15, 32'h0);

        // MSI path: R4, R5, R7, R8, R9
        wr(4'd5, 32'h0);
        msi_valid = 1'b1; msi_vec = 5'd5; msi_data = 8'hA3;
        tick();
        msi_valid = 1'b0;
        rd_check("R4 msi stat", 4'd4, 32'h0000_0020);
        rd_check("R4 msi payload", 4'd6, 32'h0000_00A3);
        tick();
        rd_check("R5 lnk bit 24", 4'd0, 32'h0100_0000);
        tick();
        rd_check("R7 host blocked by lnk mask", 4'd7, 32'h0);
        wr(4'd1, 32'h06FF_FFFF);
        tick();
        rd_check("R8 host core bit", 4'd7, 32'h0001_0000);
        check("R9 irq masked at host", {31'b0, irq_o}, 32'h0);
        wr(4'd8, 32'h00FE_F0FB);
        check("R9 irq raised", {31'b0, irq_o}, 32'h1);
        wr(4'd4, 32'h0000_0020);
        wr(4'd0, 32'h0100_0000);
        wr(4'd7, 32'h0001_0000);
        rd_check("R6 msi cleared", 4'd4, 32'h0);
        rd_check("R6 lnk bit 24 cleared", 4'd0, 32'h0);
        rd_check("R6 host cleared", 4'd7, 32'h0);
        check("R9 irq dropped", {31'b0, irq_o}, 32'h0);

        // Masked MSI vector: R4 still records, R7 no summary
        wr(4'd5, 32'h0000_0080);
        msi_valid = 1'b1; msi_vec = 5'd7; msi_data = 8'h5C;
        tick();
        msi_valid = 1'b0;
        tick();
        tick();
        rd_check("R4 masked msi recorded", 4'd4, 32'h0000_0080);
        rd_check("R7 masked msi no bit 24", 4'd0, 32'h0);
        rd_check("R4 payload updated", 4'd6, 32'h0000_005C);
        wr(4'd4, 32'h0000_0080);

        // R10 collision: event and clear of the same bit in one cycle
        wr(4'd1, 32'h07FF_FFFF);
        intx_up = 4'b0100;
        wr(4'd0, 32'h0004_0000);
        intx_up = '0;
        rd_check("R10 event beats clear", 4'd0, 32'h0004_0000);
        wr(4'd0, 32'h0000_0000);
        rd_check("R6 zero write no effect", 4'd0, 32'h0004_0000);
        wr(4'd0, 32'h0004_0000);
        rd_check("R6 clear without event", 4'd0, 32'h0);
        wr(4'd2, 32'hFFFF_FFFF);

        // Auxiliary path to the line: R8, R9
        wr(4'd3, 32'h0000_0FE0);
        pm_evt = 1'b1;
        tick();
        pm_evt = 1'b0;
        rd_check("R3 aux pm", 4'd2, 32'h0000_0010);
        tick();
        rd_check("R8 host from aux", 4'd7, 32'h0001_0000);
        check("R9 irq from aux", {31'b0, irq_o}, 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule